// File: doc/BRIEF.md
# Four-Channel DAC Two-Rank Register Core

This block is the digital register core of a four-channel digital-to-analog converter that sits behind a simple parallel host bus. Every channel owns two registers of `DATA_W` bits: a staging (input) register that the host writes and can read back, and a converter (DAC) register whose contents are presented to the analog side. A load strobe either makes both ranks of the addressed channel follow the bus together, or, with the chip deselected, copies every staging register into its converter register in the same cycle, so all four outputs change together.

All host pins are asynchronous to the system clock. They pass through a two-flop synchronizer, with the data bus carried in the same pipeline as the strobes so that data and controls stay aligned. The host reset pin clears the control pipeline at once, and the register contents are forced to zero or to midscale while it is low, chosen by a separate level pin. The data bus is split into an input, an output and an output enable; the enable is high only during a readback.

Top module: `quad_dac_regbank`

## Requirements
- R1: The channel address picks one of four channels, 0 to 3. Channel k's converter word appears on `dac_word[k*DATA_W +: DATA_W]`.
- R2: With `cs_n` high and `load_n` high, no register changes whatever the other pins do, and `data_oe` stays low.
- R3: With `cs_n` low, `rd_wr` low and `load_n` low, the addressed channel's staging register and converter register both take `data_in`. The other channels hold.
- R4: With `cs_n` low, `rd_wr` low and `load_n` high, only the addressed staging register takes `data_in`, and every converter register holds.
- R5: With `cs_n` low, `rd_wr` high and `load_n` high, `data_oe` is 1 and `data_out` carries the addressed staging register.
- R6: With `cs_n` high and `load_n` low, every converter register copies its own staging register in the same cycle.
- R7: While `host_rst_n` is low, it overrides every other pin and loads all staging and converter registers. The value is zero when `rst_mid` is 0, and the MSB alone set (0x800 for 12 bits) when `rst_mid` is 1.
- R8: Writes are level-sensitive. While the enabling pins stay asserted, a change on `data_in` keeps being written.
- R9: With `cs_n` low, `rd_wr` high and `load_n` low, the block performs a readback and no converter register changes.
- R10: A pin change is sampled by two synchronizer flops. `data_oe` and `data_out` respond after the second rising clock edge following the change. Register contents respond after the third.
- R11: When `data_oe` is 0, `data_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all host pins |
| host_rst_n | input | 1 | Active-low host reset, asynchronous assert |
| rst_mid | input | 1 | Reset level select: 0 loads zero, 1 loads midscale |
| chan_sel | input | $clog2(NUM_CH) | Channel address |
| rd_wr | input | 1 | 1 = read staging register, 0 = write |
| cs_n | input | 1 | Active-low chip select |
| load_n | input | 1 | Active-low load strobe |
| data_in | input | DATA_W | Write data from the host |
| data_out | output | DATA_W | Readback data, zero while not enabled |
| data_oe | output | 1 | High while the block drives the readback bus |
| dac_word | output | NUM_CH*DATA_W | Converter register words, channel 0 in the low bits |

## Verification
Each stimulus is applied at a falling clock edge. The readback enable and data are due after the second rising edge after that point. Register contents, and therefore `dac_word`, are due after the third. The latency test samples one falling edge before each of these points and one on it, to show the value is not early. The other tests hold each bus pattern for four cycles and then return to idle for four cycles before sampling, so every result has settled. Reset values are checked while the reset pin is still held low, and again after release.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    // Operation decoded from one sampled set of host pins.
    typedef enum logic [2:0] {
        OP_IDLE,        // chip deselected, no load
        OP_LATCH_IN,    // write the staging register only
        OP_PASS_THRU,   // write staging and converter registers together
        OP_READ,        // drive staging register onto the bus
        OP_UPDATE_ALL   // copy every staging register into its converter register
    } op_e;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int unsigned     WIDTH   = 1,
    parameter int unsigned     STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_in;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/qdac_decode.sv
module qdac_decode
    import qdac_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    localparam int unsigned SEL_W = $clog2(NUM_CH)
) (
    input  logic             cs_n,
    input  logic             load_n,
    input  logic             rd_wr,
    input  logic [SEL_W-1:0] sel,
    output op_e              op,
    output logic [NUM_CH-1:0] ch_hit
);

    // Per-channel address match, gated by chip select.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
        assign ch_hit[c] = !cs_n && (sel == SEL_W'(c));
    end

    always_comb begin
        if (!cs_n) begin
            if (rd_wr) begin
                op = OP_READ;            // load_n low with read is also a plain readback
            end else if (load_n) begin
                op = OP_LATCH_IN;
            end else begin
                op = OP_PASS_THRU;
            end
        end else begin
            op = load_n ? OP_IDLE : OP_UPDATE_ALL;
        end
    end

endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
    import qdac_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned DATA_W = 12,
    localparam int unsigned SEL_W = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     mid_sel,
    input  op_e                      op,
    input  logic [NUM_CH-1:0]        ch_hit,
    input  logic [SEL_W-1:0]         sel,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_CH*DATA_W-1:0] dac_words,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_oe
);

    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    typedef logic [NUM_CH-1:0][DATA_W-1:0] bankvec_t;
    typedef struct packed {
        bankvec_t in_r;
        bankvec_t dac_r;
    } state_t;

    state_t            st_d, st_q;
    logic [DATA_W-1:0] fill_code;

    assign fill_code = mid_sel ? MID_CODE : '0;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++) begin
                st_d.in_r[c]  = fill_code;
                st_d.dac_r[c] = fill_code;
            end
        end else begin
            case (op)
                OP_LATCH_IN: begin
                    for (int c = 0; c < NUM_CH; c++) begin
                        if (ch_hit[c]) st_d.in_r[c] = wr_data;
                    end
                end
                OP_PASS_THRU: begin
                    for (int c = 0; c < NUM_CH; c++) begin
                        if (ch_hit[c]) begin
                            st_d.in_r[c]  = wr_data;
                            st_d.dac_r[c] = wr_data;
                        end
                    end
                end
                OP_UPDATE_ALL: st_d.dac_r = st_q.in_r;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dac_words = st_q.dac_r;
    assign rd_oe     = (op == OP_READ) && !rst;
    assign rd_data   = rd_oe ? st_q.in_r[sel] : '0;

    // Deselected and idle: nothing moves.
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE) |=> $stable(st_q))
        else $error("idle cycle changed register state");

    // Staging-only write leaves every converter register alone.
    assert_latch_only_R4: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LATCH_IN) |=> $stable(st_q.dac_r))
        else $error("staging write disturbed a converter register");

    // Simultaneous update copies the previous staging contents.
    assert_update_all_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_UPDATE_ALL) |=> (st_q.dac_r == $past(st_q.in_r)))
        else $error("simultaneous update mismatch");

    // Readback in any load state leaves all registers untouched.
    assert_read_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_READ) |=> $stable(st_q))
        else $error("readback changed register state");

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // Transparent write reaches both ranks of the addressed channel.
        assert_pass_thru_R3: assert property (@(posedge clk) disable iff (rst)
            (op == OP_PASS_THRU && ch_hit[c]) |=>
                (st_q.in_r[c] == $past(wr_data) && st_q.dac_r[c] == $past(wr_data)))
            else $error("transparent write missed channel %0d", c);
    end

endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
    import qdac_pkg::*;
#(
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned NUM_CH      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       host_rst_n,
    input  logic                       rst_mid,
    input  logic [$clog2(NUM_CH)-1:0]  chan_sel,
    input  logic                       rd_wr,
    input  logic                       cs_n,
    input  logic                       load_n,
    input  logic [DATA_W-1:0]          data_in,
    output logic [DATA_W-1:0]          data_out,
    output logic                       data_oe,
    output logic [NUM_CH*DATA_W-1:0]   dac_word
);

    localparam int unsigned SEL_W = $clog2(NUM_CH);
    localparam int unsigned HB_W  = 3 + SEL_W + DATA_W;
    // Pipeline reset value: chip deselected, load inactive.
    localparam logic [HB_W-1:0] HB_IDLE = {2'b11, {(HB_W-2){1'b0}}};

    logic [HB_W-1:0]   hb_raw, hb_s;
    logic              rel_q, mid_s, rst_act;
    logic              s_cs_n, s_load_n, s_rd_wr;
    logic [SEL_W-1:0]  s_sel;
    logic [DATA_W-1:0] s_din;
    op_e               op;
    logic [NUM_CH-1:0] ch_hit;

    assign hb_raw = {cs_n, load_n, rd_wr, chan_sel, data_in};

    // Reset: asserts at once, releases after SYNC_STAGES clock edges.
    qdac_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
        .clk(clk), .arst_n(host_rst_n), .d_in(1'b1), .d_out(rel_q)
    );
    assign rst_act = !rel_q;

    // Host strobes, address and data travel together.
    qdac_sync #(.WIDTH(HB_W), .STAGES(SYNC_STAGES), .RST_VAL(HB_IDLE)) u_host_sync (
        .clk(clk), .arst_n(host_rst_n), .d_in(hb_raw), .d_out(hb_s)
    );

    // Reset level pin keeps sampling during reset.
    qdac_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mid_sync (
        .clk(clk), .arst_n(1'b1), .d_in(rst_mid), .d_out(mid_s)
    );

    assign s_din    = hb_s[DATA_W-1:0];
    assign s_sel    = hb_s[DATA_W +: SEL_W];
    assign s_rd_wr  = hb_s[DATA_W+SEL_W];
    assign s_load_n = hb_s[DATA_W+SEL_W+1];
    assign s_cs_n   = hb_s[DATA_W+SEL_W+2];

    qdac_decode #(.NUM_CH(NUM_CH)) u_decode (
        .cs_n(s_cs_n), .load_n(s_load_n), .rd_wr(s_rd_wr), .sel(s_sel),
        .op(op), .ch_hit(ch_hit)
    );

    qdac_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst(rst_act), .mid_sel(mid_s), .op(op), .ch_hit(ch_hit),
        .sel(s_sel), .wr_data(s_din), .dac_words(dac_word),
        .rd_data(data_out), .rd_oe(data_oe)
    );

    // Bus released during a readback cycle never coincides with converter motion.
    assert_read_quiet_R5: assert property (@(posedge clk) disable iff (rst_act)
        data_oe |=> $stable(dac_word))
        else $error("converter words moved during readback");

endmodule

// File: tb/tb_quad_dac_regbank.sv
module tb_quad_dac_regbank;

    localparam int W = 12;
    localparam int N = 4;
    localparam logic [W-1:0] MID = 12'h800;

    logic         clk = 1'b0;
    logic         host_rst_n, rst_mid, rd_wr, cs_n, load_n;
    logic [1:0]   chan_sel;
    logic [W-1:0] data_in, data_out;
    logic         data_oe;
    logic [N*W-1:0] dac_word;

    logic [W-1:0] m_in [N];
    logic [W-1:0] m_dac[N];
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    quad_dac_regbank #(.DATA_W(W), .NUM_CH(N), .SYNC_STAGES(2)) dut (
        .clk(clk), .host_rst_n(host_rst_n), .rst_mid(rst_mid), .chan_sel(chan_sel),
        .rd_wr(rd_wr), .cs_n(cs_n), .load_n(load_n), .data_in(data_in),
        .data_out(data_out), .data_oe(data_oe), .dac_word(dac_word)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apply(input logic c, input logic r, input logic l,
                         input logic [1:0] s, input logic [W-1:0] d);
        @(negedge clk);
        cs_n = c; rd_wr = r; load_n = l; chan_sel = s; data_in = d;
    endtask

    task automatic go_idle();
        apply(1'b1, 1'b0, 1'b1, 2'd0, '0);
    endtask

    task automatic run_op(input logic c, input logic r, input logic l,
                          input logic [1:0] s, input logic [W-1:0] d);
        apply(c, r, l, s, d);
        settle(4);
        go_idle();
        settle(4);
    endtask

    task automatic check_dacs(input string req);
        for (int c = 0; c < N; c++) chk(req, "dac_word", dac_word[c*W +: W], m_dac[c]);
    endtask

    task automatic readback(input int c, input string req);
        apply(1'b0, 1'b1, 1'b1, 2'(c), '0);
        settle(3);
        chk(req, "data_oe", W'(data_oe), W'(1));
        chk(req, "data_out", data_out, m_in[c]);
        go_idle();
        settle(3);
        chk("R11", "data_oe idle", W'(data_oe), W'(0));
        chk("R11", "data_out idle", data_out, '0);
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst_mid = m;
        settle(3);
        host_rst_n = 1'b0;
        settle(4);
        host_rst_n = 1'b1;
        settle(4);
        for (int c = 0; c < N; c++) begin
            m_in[c]  = m ? MID : '0;
            m_dac[c] = m ? MID : '0;
        end
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        host_rst_n = 1'b0; rst_mid = 1'b0;
        cs_n = 1'b1; load_n = 1'b1; rd_wr = 1'b0; chan_sel = '0; data_in = '0;
        settle(5);
        host_rst_n = 1'b1;
        settle(4);
        for (int c = 0; c < N; c++) begin m_in[c] = '0; m_dac[c] = '0; end

        // R7 reset to zero, both ranks
        check_dacs("R7");
        chk("R11", "data_oe after reset", W'(data_oe), W'(0));
        for (int c = 0; c < N; c++) readback(c, "R7");

        // R7 reset to midscale
        do_reset(1'b1);
        check_dacs("R7");
        for (int c = 0; c < N; c++) readback(c, "R7");

        // R4 staging-only writes per channel; R1 and R5 via readback
        for (int c = 0; c < N; c++) begin
            logic [W-1:0] v;
            v = W'(12'h1A5 + c * 12'h2C3);
            run_op(1'b0, 1'b0, 1'b1, 2'(c), v);
            m_in[c] = v;
            check_dacs("R4");
        end
        for (int c = 0; c < N; c++) readback(c, "R1");

        // R6 simultaneous update
        run_op(1'b1, 1'b0, 1'b0, 2'd2, 12'hFFF);
        for (int c = 0; c < N; c++) m_dac[c] = m_in[c];
        check_dacs("R6");

        // R2 deselected: writes and reads ignored
        for (int c = 0; c < N; c++) begin
            apply(1'b1, 1'b1, 1'b1, 2'(c), 12'hC3C);
            settle(3);
            chk("R2", "data_oe deselected", W'(data_oe), W'(0));
            chk("R2", "data_out deselected", data_out, '0);
            go_idle();
            settle(2);
            run_op(1'b1, 1'b0, 1'b1, 2'(c), 12'h3C3);
        end
        check_dacs("R2");
        for (int c = 0; c < N; c++) readback(c, "R2");

        // R3 transparent writes, sweep over channels and values
        for (int c = 0; c < N; c++) begin
            for (int k = 0; k < 16; k++) begin
                logic [W-1:0] v;
                v = W'(k * 273 + c * 977);
                run_op(1'b0, 1'b0, 1'b0, 2'(c), v);
                m_in[c] = v; m_dac[c] = v;
                check_dacs("R3");
            end
            readback(c, "R3");
        end

        // R9 read with load low: readback only
        run_op(1'b0, 1'b0, 1'b1, 2'd1, 12'h5A5);
        m_in[1] = 12'h5A5;
        apply(1'b0, 1'b1, 1'b0, 2'd1, 12'h0F0);
        settle(3);
        chk("R9", "data_oe", W'(data_oe), W'(1));
        chk("R9", "data_out", data_out, 12'h5A5);
        settle(3);
        go_idle();
        settle(4);
        check_dacs("R9");

        // R8 level-sensitive: data change while held keeps being written
        apply(1'b0, 1'b0, 1'b1, 2'd2, 12'h111);
        settle(4);
        data_in = 12'h222;
        settle(4);
        go_idle();
        settle(4);
        m_in[2] = 12'h222;
        readback(2, "R8");
        check_dacs("R8");

        // R10 latency of a transparent write and of a readback
        apply(1'b0, 1'b0, 1'b0, 2'd3, 12'hABC);
        settle(2);
        chk("R10", "dac3 before third edge", dac_word[3*W +: W], m_dac[3]);
        settle(1);
        chk("R10", "dac3 at third edge", dac_word[3*W +: W], 12'hABC);
        go_idle();
        settle(4);
        m_in[3] = 12'hABC; m_dac[3] = 12'hABC;
        apply(1'b0, 1'b1, 1'b1, 2'd3, '0);
        settle(1);
        chk("R10", "data_oe before second edge", W'(data_oe), W'(0));
        settle(1);
        chk("R10", "data_oe at second edge", W'(data_oe), W'(1));
        chk("R10", "data_out at second edge", data_out, 12'hABC);
        go_idle();
        settle(4);

        // R7 reset overrides a held transparent write
        @(negedge clk); rst_mid = 1'b1;
        apply(1'b0, 1'b0, 1'b0, 2'd0, 12'h0FF);
        settle(4);
        host_rst_n = 1'b0;
        settle(3);
        for (int c = 0; c < N; c++) chk("R7", "dac during reset", dac_word[c*W +: W], MID);
        go_idle();
        settle(3);
        host_rst_n = 1'b1;
        settle(4);
        for (int c = 0; c < N; c++) begin m_in[c] = MID; m_dac[c] = MID; end
        check_dacs("R7");

        // R7 reset back to zero after data present
        do_reset(1'b0);
        check_dacs("R7");
        for (int c = 0; c < N; c++) readback(c, "R7");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule